// File: doc/BRIEF.md
# Banked Hardware-Monitor Register File

This block holds the 256-byte register space of a hardware monitor. It sits behind a serial management bus front end. That front end supplies byte writes, byte reads and word reads of the temperature-sensor registers. The physical bus shifter and the analog converters are outside the block. The block only sees decoded strobes, the current voltage samples and the temperature sample.

Several addresses are treated specially:

- Two alias windows fold onto lower registers.
- One address returns either byte of a 16-bit vendor identifier, depending on a flag bit.
- Writes to a few control registers re-bind the bus addresses of the main device and of two auxiliary temperature sensors, or select an active bank.

Setting the initialization bit restores every register to its default but keeps the main bus address.

The register array has a single port. After power-on reset, and after an initialization request, the control state machine refills the array. It writes one entry per cycle in state SWEEP and raises `busy` while it does so. Transitions:

- SWEEP → IDLE once entry 0xFF has been written.
- IDLE → SWEEP on an initialization write.
- IDLE → WORD2 on a word read, because the second byte needs a second array access.
- WORD2 → IDLE unconditionally.

Top module: `mon_regfile`

## Requirements
- R1: After reset, and after an initialization request, `busy` stays high for exactly 256 cycles. Once it falls, the defaults are in place: 0x40=0x01, 0x46=0x40, 0x47=0x50, 0x49=0x02, 0x4A=0x01, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80, 0x57=0x80 and 0x48 = main bus address. Every other register not listed in R2 or R12 reads 0x00.
- R2: Registers 0x20 to 0x26 load bits 11:4 of voltage samples 0 to 6, each 12 bits wide and packed from bit 0 upward in `volt_in`. Register 0x27 loads `temp_in`.
- R3: An access to addresses 0x60 to 0x7F reaches register (address − 0x40).
- R4: An access to addresses 0x80 to 0x92 reaches register (address − 0x80). Address 0x93 is its own register.
- R5: A read of 0x4F returns the vendor ID high byte when bit 7 of 0x4E is 1, and the low byte when it is 0. The default ID is 0x5CA3.
- R6: `main_addr` is 0x2D after power-on reset. A write to 0x48 loads it with bits 6:0 of the data, while the register itself keeps all 8 bits.
- R7: `t2_addr` is 0x48 + bits 2:0 of register 0x4A, or 0 when bit 3 is 1. `t3_addr` is 0x48 + bits 6:4, or 0 when bit 7 is 1.
- R8: A write to 0x4E sets `bank` to 0 if bit 0 is 1, else 1 if bit 1 is 1, else 2 if bit 2 is 1. If none of these bits is set, the previous bank is kept. Reset gives bank 0.
- R9: A write to 0x40 with bit 7 set starts a refill. `main_addr` keeps its value, while `t2_addr`, `t3_addr`, `bank` and the vendor byte flag return to their defaults.
- R10: A word read with `wcmd` 0, 1, 2 or 3 reads the register pair (0x50,0x51), (0x52,0x52), (0x53,0x54) or (0x55,0x56). `word_data` = {second, first} two cycles after the strobe.
- R11: A byte read shows on `rdata` one cycle after the strobe. While `busy` is high, writes and reads are ignored and `rdata` holds its value.
- R12: Registers 0xC0 to 0xDF reset to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 8 | Byte access address |
| wdata | input | 8 | Byte write data |
| rdata | output | 8 | Byte read data, registered |
| wrd_en | input | 1 | Word read strobe for temperature-sensor registers |
| wcmd | input | 2 | Word read selector |
| word_data | output | 16 | Word read result, second byte high |
| volt_in | input | 84 | Seven packed 12-bit voltage samples |
| temp_in | input | 8 | Temperature sample |
| busy | output | 1 | High during refill or second word cycle |
| main_addr | output | 7 | Main bus address |
| t2_addr | output | 7 | Second temperature sensor address, 0 = off |
| t3_addr | output | 7 | Third temperature sensor address, 0 = off |
| bank | output | 2 | Active bank |

## Verification
Most faults in this block would show up at the ports:

- A wrong sweep counter or state change shows as a `busy` pulse that is not exactly 256 cycles long, or as a wrong default read right after `busy` falls.
- A bad alias decode returns a value written elsewhere on the very next byte read.
- Corrupted mirror flops for 0x48, 0x4A or 0x4E change `main_addr`, `t2_addr`, `t3_addr` or `bank` one cycle after the write.
- A wrong vendor flag shows on the next 0x4F read.
- A stuck WORD2 state keeps `busy` high, and a wrong first-byte latch corrupts the low half of `word_data` two cycles after the strobe.

// File: rtl/mon_pkg.sv
package mon_pkg;

    typedef enum logic [1:0] {
        ST_SWEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WORD2 = 2'd2
    } mon_state_e;

    localparam logic [7:0] REG_INIT = 8'h40;
    localparam logic [7:0] REG_MAIN = 8'h48;
    localparam logic [7:0] REG_TCFG = 8'h4A;
    localparam logic [7:0] REG_BSEL = 8'h4E;
    localparam logic [7:0] REG_VID  = 8'h4F;
    localparam logic [7:0] TCFG_RST = 8'h01;

    // First register of a temperature-sensor word read
    function automatic logic [7:0] word_first_addr(input logic [1:0] c);
        unique case (c)
            2'd0:    return 8'h50;
            2'd1:    return 8'h52;
            2'd2:    return 8'h53;
            default: return 8'h55;
        endcase
    endfunction

    // Second register of a temperature-sensor word read
    function automatic logic [7:0] word_second_addr(input logic [1:0] c);
        unique case (c)
            2'd0:    return 8'h51;
            2'd1:    return 8'h52;
            2'd2:    return 8'h54;
            default: return 8'h56;
        endcase
    endfunction

endpackage

// File: rtl/mon_alias.sv
module mon_alias (
    input  logic [7:0] a,
    output logic [7:0] p
);
    always_comb begin
        if (a >= 8'h60 && a <= 8'h7F)
            p = a - 8'h40;
        else if (a >= 8'h80 && a <= 8'h92)
            p = a - 8'h80;
        else
            p = a;
    end
endmodule

// File: rtl/mon_defaults.sv
module mon_defaults #(
    parameter logic [15:0] VENDOR_ID = 16'h5CA3,
    parameter int          NUM_VIN   = 7,
    parameter int          VOLT_W    = 12
) (
    input  logic [7:0]                idx,
    input  logic [NUM_VIN*VOLT_W-1:0] volts,
    input  logic [7:0]                temp,
    input  logic [6:0]                main_addr,
    output logic [7:0]                value
);
    localparam int VSHIFT = VOLT_W - 8;

    always_comb begin
        value = 8'h00;
        if (idx[7:5] == 3'b110)
            value = 8'hFF;
        for (int i = 0; i < NUM_VIN; i++) begin
            if (idx == 8'(32'h20 + i))
                value = volts[i*VOLT_W+VSHIFT +: 8];
        end
        unique case (idx)
            8'h27:   value = temp;
            8'h40:   value = 8'h01;
            8'h46:   value = 8'h40;
            8'h47:   value = 8'h50;
            8'h48:   value = {1'b0, main_addr};
            8'h49:   value = 8'h02;
            8'h4A:   value = 8'h01;
            8'h4B:   value = 8'h44;
            8'h4C:   value = 8'h01;
            8'h4D:   value = 8'h15;
            8'h4E:   value = 8'h80;
            8'h4F:   value = VENDOR_ID[15:8];
            8'h57:   value = 8'h80;
            default: ;
        endcase
    end
endmodule

// File: rtl/mon_bus_addr.sv
module mon_bus_addr #(
    parameter logic [6:0] SENSOR_BASE = 7'h48
) (
    input  logic [7:0] cfg,
    output logic [6:0] t2,
    output logic [6:0] t3
);
    assign t2 = cfg[3] ? 7'h00 : (SENSOR_BASE + {4'b0, cfg[2:0]});
    assign t3 = cfg[7] ? 7'h00 : (SENSOR_BASE + {4'b0, cfg[6:4]});
endmodule

// File: rtl/mon_regfile.sv
module mon_regfile
    import mon_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h5CA3,
    parameter int          NUM_VIN       = 7,
    parameter int          VOLT_W        = 12,
    parameter logic [6:0]  MAIN_ADDR_RST = 7'h2D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [7:0]                addr,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata,
    input  logic                      wrd_en,
    input  logic [1:0]                wcmd,
    output logic [15:0]               word_data,
    input  logic [NUM_VIN*VOLT_W-1:0] volt_in,
    input  logic [7:0]                temp_in,
    output logic                      busy,
    output logic [6:0]                main_addr,
    output logic [6:0]                t2_addr,
    output logic [6:0]                t3_addr,
    output logic [1:0]                bank
);
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    mon_state_e     state, state_n;
    logic [AW-1:0]  sweep_idx;
    logic [7:0]     mem [DEPTH];
    logic [AW-1:0]  paddr, rd_addr, wa;
    logic [7:0]     dflt, wd, rd_byte, tcfg, word_first;
    logic           we, vid_hi, do_wr, do_rd, do_wrd, do_init;
    logic [1:0]     wcmd_r;

    mon_alias u_alias (.a(addr), .p(paddr));

    mon_defaults #(.VENDOR_ID(VENDOR_ID), .NUM_VIN(NUM_VIN), .VOLT_W(VOLT_W)) u_dflt (
        .idx(sweep_idx), .volts(volt_in), .temp(temp_in),
        .main_addr(main_addr), .value(dflt)
    );

    mon_bus_addr u_baddr (.cfg(tcfg), .t2(t2_addr), .t3(t3_addr));

    assign busy    = (state != ST_IDLE);
    assign do_wr   = (state == ST_IDLE) && wr_en;
    assign do_rd   = (state == ST_IDLE) && !wr_en && rd_en;
    assign do_wrd  = (state == ST_IDLE) && !wr_en && !rd_en && wrd_en;
    assign do_init = do_wr && (paddr == REG_INIT) && wdata[7];

    // Single array port: address and write selection
    always_comb begin
        we      = 1'b0;
        wa      = paddr;
        wd      = wdata;
        rd_addr = paddr;
        unique case (state)
            ST_SWEEP: begin
                we = 1'b1;
                wa = sweep_idx;
                wd = dflt;
            end
            ST_IDLE: begin
                we = do_wr;
                if (do_wrd)
                    rd_addr = word_first_addr(wcmd);
            end
            ST_WORD2: rd_addr = word_second_addr(wcmd_r);
            default: ;
        endcase
    end

    assign rd_byte = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_SWEEP;
        else
            state <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_SWEEP: if (sweep_idx == 8'hFF) state_n = ST_IDLE;
            ST_IDLE: begin
                if (do_init)
                    state_n = ST_SWEEP;
                else if (do_wrd)
                    state_n = ST_WORD2;
            end
            ST_WORD2: state_n = ST_IDLE;
            default:  state_n = ST_SWEEP;
        endcase
    end

    // Outputs and mirrored control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_idx  <= '0;
            main_addr  <= MAIN_ADDR_RST;
            tcfg       <= TCFG_RST;
            vid_hi     <= 1'b1;
            bank       <= 2'd0;
            rdata      <= 8'h00;
            word_data  <= 16'h0000;
            wcmd_r     <= 2'd0;
            word_first <= 8'h00;
        end else begin
            unique case (state)
                ST_SWEEP: sweep_idx <= sweep_idx + 1'b1;
                ST_IDLE: begin
                    if (do_wr) begin
                        unique case (paddr)
                            REG_MAIN: main_addr <= wdata[6:0];
                            REG_TCFG: tcfg <= wdata;
                            REG_BSEL: begin
                                vid_hi <= wdata[7];
                                if (wdata[0])      bank <= 2'd0;
                                else if (wdata[1]) bank <= 2'd1;
                                else if (wdata[2]) bank <= 2'd2;
                            end
                            REG_INIT: begin
                                if (wdata[7]) begin
                                    sweep_idx <= '0;
                                    tcfg      <= TCFG_RST;
                                    vid_hi    <= 1'b1;
                                    bank      <= 2'd0;
                                end
                            end
                            default: ;
                        endcase
                    end else if (do_rd) begin
                        if (paddr == REG_VID)
                            rdata <= vid_hi ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
                        else
                            rdata <= rd_byte;
                    end else if (do_wrd) begin
                        wcmd_r     <= wcmd;
                        word_first <= rd_byte;
                    end
                end
                ST_WORD2: word_data <= {rd_byte, word_first};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mon_regfile_chk.sv
module mon_regfile_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h5CA3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       busy,
    input logic [6:0] main_addr,
    input logic [6:0] t2_addr,
    input logic [6:0] t3_addr,
    input logic [1:0] bank
);
    assert_main_addr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == 8'h48) |=> (main_addr == $past(wdata[6:0])));

    assert_t2_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_addr == 7'h00) || (t2_addr[6:3] == 4'h9));

    assert_t3_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t3_addr == 7'h00) || (t3_addr[6:3] == 4'h9));

    assert_bank_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == 8'h4E && wdata[0]) |=> (bank == 2'd0));

    assert_bank_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bank != 2'd3);

    assert_init_keeps_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == 8'h40 && wdata[7]) |=> (busy && $stable(main_addr)));

    assert_busy_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(main_addr) && $stable(rdata)));

    assert_vid_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en && rd_en && addr == 8'h4F) |=>
        (rdata == VENDOR_ID[15:8] || rdata == VENDOR_ID[7:0]));
endmodule

bind mon_regfile mon_regfile_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .main_addr(main_addr),
    .t2_addr(t2_addr), .t3_addr(t3_addr), .bank(bank)
);

// File: tb/tb_mon_regfile.sv
`timescale 1ns/1ps
module tb_mon_regfile;
    localparam int NV = 7;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, wrd_en = 0;
    logic [7:0] addr = 0, wdata = 0, temp_in = 8'h37;
    logic [1:0] wcmd = 0;
    logic [NV*VW-1:0] volt_in;
    logic [7:0] rdata;
    logic [15:0] word_data;
    logic busy;
    logic [6:0] main_addr, t2_addr, t3_addr;
    logic [1:0] bank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mon_regfile dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wrd_en(wrd_en), .wcmd(wcmd),
        .word_data(word_data), .volt_in(volt_in), .temp_in(temp_in),
        .busy(busy), .main_addr(main_addr), .t2_addr(t2_addr),
        .t3_addr(t3_addr), .bank(bank)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic rdw(input logic [1:0] c, output logic [15:0] d);
        @(negedge clk);
        wrd_en = 1; wcmd = c;
        @(negedge clk);
        wrd_en = 0;
        @(negedge clk);
        d = word_data;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        int n;
        logic [7:0] v;
        chk("R6 power-on main addr", 16'(main_addr), 16'h2D);
        chk("R1 busy at reset", 16'(busy), 16'h1);
        busy_len(n);
        chk("R1 reset sweep length", 16'(n), 16'd256);
        chk("R7 default t2", 16'(t2_addr), 16'h49);
        chk("R7 default t3", 16'(t3_addr), 16'h48);
        chk("R8 default bank", 16'(bank), 16'h0);
        rd(8'h40, v); chk("R1 0x40", 16'(v), 16'h01);
        rd(8'h46, v); chk("R1 0x46", 16'(v), 16'h40);
        rd(8'h47, v); chk("R1 0x47", 16'(v), 16'h50);
        rd(8'h48, v); chk("R1 0x48", 16'(v), 16'h2D);
        rd(8'h49, v); chk("R1 0x49", 16'(v), 16'h02);
        rd(8'h4A, v); chk("R1 0x4A", 16'(v), 16'h01);
        rd(8'h4B, v); chk("R1 0x4B", 16'(v), 16'h44);
        rd(8'h4C, v); chk("R1 0x4C", 16'(v), 16'h01);
        rd(8'h4D, v); chk("R1 0x4D", 16'(v), 16'h15);
        rd(8'h4E, v); chk("R1 0x4E", 16'(v), 16'h80);
        rd(8'h57, v); chk("R1 0x57", 16'(v), 16'h80);
        rd(8'h50, v); chk("R1 0x50 zero", 16'(v), 16'h00);
        rd(8'hC0, v); chk("R12 0xC0", 16'(v), 16'hFF);
        rd(8'hDF, v); chk("R12 0xDF", 16'(v), 16'hFF);
        rd(8'hBF, v); chk("R12 0xBF below window", 16'(v), 16'h00);
        rd(8'hE0, v); chk("R12 0xE0 above window", 16'(v), 16'h00);
    endtask

    task automatic t_samples();
        logic [7:0] v;
        for (int i = 0; i < NV; i++) begin
            logic [11:0] s;
            s = volt_in[i*VW +: VW];
            rd(8'(8'h20 + i), v);
            chk("R2 voltage reg", 16'(v), 16'(s >> 4));
        end
        rd(8'h27, v); chk("R2 temperature reg", 16'(v), 16'h37);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        wr(8'h65, 8'h3C);
        rd(8'h25, v); chk("R3 0x65 -> 0x25", 16'(v), 16'h3C);
        rd(8'h65, v); chk("R3 read via alias", 16'(v), 16'h3C);
        wr(8'h7F, 8'h9E);
        rd(8'h3F, v); chk("R3 0x7F -> 0x3F", 16'(v), 16'h9E);
        wr(8'h05, 8'h77);
        rd(8'h85, v); chk("R4 0x85 -> 0x05", 16'(v), 16'h77);
        wr(8'h92, 8'h11);
        rd(8'h12, v); chk("R4 0x92 -> 0x12", 16'(v), 16'h11);
        wr(8'h93, 8'h22);
        rd(8'h13, v); chk("R4 0x93 not aliased", 16'(v), 16'h00);
        rd(8'h93, v); chk("R4 0x93 own reg", 16'(v), 16'h22);
    endtask

    task automatic t_vendor_bank();
        logic [7:0] v;
        rd(8'h4F, v); chk("R5 vendor high", 16'(v), 16'h5C);
        wr(8'h4E, 8'h00);
        rd(8'h4F, v); chk("R5 vendor low", 16'(v), 16'hA3);
        chk("R8 no bits keeps bank 0", 16'(bank), 16'h0);
        wr(8'h4E, 8'h86);
        chk("R8 bit1 over bit2", 16'(bank), 16'h1);
        rd(8'h4F, v); chk("R5 vendor high again", 16'(v), 16'h5C);
        wr(8'h4E, 8'h04);
        chk("R8 bit2", 16'(bank), 16'h2);
        wr(8'h4E, 8'h00);
        chk("R8 no bits keeps bank 2", 16'(bank), 16'h2);
        wr(8'h4E, 8'h07);
        chk("R8 bit0 wins", 16'(bank), 16'h0);
        wr(8'h4E, 8'h04);
    endtask

    task automatic t_addrs();
        logic [7:0] v;
        wr(8'h48, 8'hAB);
        chk("R6 main addr low 7 bits", 16'(main_addr), 16'h2B);
        rd(8'h48, v); chk("R6 reg keeps 8 bits", 16'(v), 16'hAB);
        wr(8'h4A, 8'h35);
        chk("R7 t2 = 0x48+5", 16'(t2_addr), 16'h4D);
        chk("R7 t3 = 0x48+3", 16'(t3_addr), 16'h4B);
        wr(8'h4A, 8'h0F);
        chk("R7 t2 disabled", 16'(t2_addr), 16'h00);
        chk("R7 t3 = 0x48", 16'(t3_addr), 16'h48);
        wr(8'h4A, 8'hF2);
        chk("R7 t2 = 0x4A", 16'(t2_addr), 16'h4A);
        chk("R7 t3 disabled", 16'(t3_addr), 16'h00);
    endtask

    task automatic t_word();
        logic [15:0] w;
        wr(8'h50, 8'h12); wr(8'h51, 8'h34);
        wr(8'h52, 8'h9C);
        wr(8'h53, 8'hAA); wr(8'h54, 8'hBB);
        wr(8'h55, 8'h01); wr(8'h56, 8'h02);
        rdw(2'd0, w); chk("R10 cmd0 pair", w, 16'h3412);
        rdw(2'd1, w); chk("R10 cmd1 config", w, 16'h9C9C);
        rdw(2'd2, w); chk("R10 cmd2 pair", w, 16'hBBAA);
        rdw(2'd3, w); chk("R10 cmd3 pair", w, 16'h0201);
    endtask

    task automatic t_init();
        int n;
        logic [7:0] v, keep;
        rd(8'h40, keep);
        wr(8'h40, 8'h80);
        chk("R9 busy after init", 16'(busy), 16'h1);
        @(negedge clk);
        wr_en = 1; addr = 8'h48; wdata = 8'h10;
        @(negedge clk);
        wr_en = 0; rd_en = 1; addr = 8'h93;
        @(negedge clk);
        rd_en = 0;
        chk("R11 write ignored while busy", 16'(main_addr), 16'h2B);
        chk("R11 rdata held while busy", 16'(rdata), 16'(keep));
        busy_len(n);
        chk("R1 init sweep length", 16'(n), 16'd253);
        chk("R9 main addr kept", 16'(main_addr), 16'h2B);
        chk("R9 t2 default", 16'(t2_addr), 16'h49);
        chk("R9 t3 default", 16'(t3_addr), 16'h48);
        chk("R9 bank default", 16'(bank), 16'h0);
        rd(8'h48, v); chk("R9 0x48 holds kept addr", 16'(v), 16'h2B);
        rd(8'h50, v); chk("R9 0x50 cleared", 16'(v), 16'h00);
        rd(8'h4E, v); chk("R9 0x4E default", 16'(v), 16'h80);
        rd(8'h4F, v); chk("R9 vendor flag default", 16'(v), 16'h5C);
    endtask

    task automatic t_busy_word();
        logic [7:0] v;
        @(negedge clk);
        wrd_en = 1; wcmd = 2'd0;
        @(negedge clk);
        wrd_en = 0;
        chk("R11 busy in second word cycle", 16'(busy), 16'h1);
        wr_en = 1; addr = 8'h31; wdata = 8'h66;
        @(negedge clk);
        wr_en = 0;
        chk("R11 busy clears", 16'(busy), 16'h0);
        rd(8'h31, v); chk("R11 write in word cycle ignored", 16'(v), 16'h00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NV; i++)
            volt_in[i*VW +: VW] = {4'(i + 1), 8'hA5};
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_samples();
        t_alias();
        t_vendor_bank();
        t_addrs();
        t_word();
        t_init();
        t_busy_word();
        done = 1;
        finish_run();
    end
endmodule